// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of an eight-line programmable interrupt controller. It sits on a simple synchronous bus that has one address bit, a write strobe, a read strobe and 8-bit data. It decodes setup writes and run-time command writes, and it holds the controller's configuration: trigger mode, single or cascade operation, vector base, cascade map or slave identity, automatic end-of-interrupt and the line mask. The priority core reads this configuration. In return the core supplies its request and in-service registers, which the block reads back to software and uses to resolve end-of-interrupt commands.

The two addresses carry seven kinds of word. A write to offset 0 with bit 4 set starts a new setup sequence. After that, writes to offset 1 are consumed in turn as the vector word, the cascade word and the mode word. The cascade word is used only in cascade mode, and the mode word only when the first word asks for it. When no sequence is open, offset 1 is the mask register. Offset 0 writes with bit 4 clear are run-time commands, chosen by bit 3. Rotation, priority-setting and special-mask commands are accepted and have no effect.

Every write and read completes in the cycle its strobe is high. No back-pressure exists. Read data is registered and is valid from the cycle after the read strobe. It holds until the next read.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset, mask is 0, auto_eoi is 0, no setup sequence is open, offset-0 reads return irr_in, and edge_mode, single_mode, vec_base and cascade_map are 0.
- R2: A write to offset 0 with wdata[4]=1 clears mask and sets edge_mode=wdata[3] and single_mode=wdata[1]. It records whether a mode word will follow (wdata[0]=1) and clears auto_eoi when wdata[0]=0. The next offset-1 write is then the vector word.
- R3: The vector word sets vec_base to wdata with bits 2:0 forced to 0. With single_mode=1 it also clears cascade_map and closes the sequence, even if a mode word was requested. Otherwise the cascade word comes next.
- R4: When is_master=1, the cascade word stores all eight bits in cascade_map. When is_master=0, it stores wdata[2:0] zero-extended. The mode word comes next if it was requested; otherwise the sequence closes.
- R5: The mode word sets auto_eoi=wdata[1] and closes the sequence. Its other bits change no output.
- R6: An offset-1 write while no sequence is open loads mask with wdata. mask changes only on a write.
- R7: An offset-0 write with wdata[4:3]=00 and wdata[7:5]=001 raises eoi_valid for exactly the next cycle, with eoi_line set to the highest set bit of isr_in at the write. If isr_in is 0, no strobe is raised.
- R8: An offset-0 write with wdata[4:3]=00 and wdata[7:5]=011 raises eoi_valid for the next cycle with eoi_line=wdata[2:0].
- R9: Offset-0 writes with wdata[4:3]=00 and any other code in wdata[7:5] raise no strobe and change no output.
- R10: An offset-0 write with wdata[4:3]=01 and wdata[1]=1 selects offset-0 reads: irr_in if wdata[0]=1, isr_in if wdata[0]=0. When wdata[1]=0 the selection is unchanged.
- R11: On a read strobe, rdata takes mask for offset 1, or the selected core register for offset 0, in the next cycle. rdata holds while no read strobe is high.
- R12: A first setup word written in the middle of a sequence restarts the sequence from the vector word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | Role strap: 1 master, 0 slave |
| addr | input | 1 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irr_in | input | 8 | Request register from the priority core |
| isr_in | input | 8 | In-service register from the priority core |
| eoi_valid | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_line | output | 3 | Line cleared by the strobe |
| edge_mode | output | 1 | 1 edge triggering, 0 level |
| single_mode | output | 1 | 1 single controller, 0 cascade |
| vec_base | output | 8 | Vector base, low three bits zero |
| cascade_map | output | 8 | Slave map (master) or slave identity (slave) |
| auto_eoi | output | 1 | Automatic end-of-interrupt enabled |
| mask | output | 8 | Line mask |

## Verification
The bench builds the block with the default eight lines. At that width every command field lands on its defined bit, and the full highest-bit search for non-specific end-of-interrupt is exercised. The role strap is driven to both values across two reset periods, which covers the master and slave forms of the cascade word. The short and long setup sequences are run, including a restart in the middle of a sequence and a single-mode sequence that requested a mode word it never consumes.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_VEC, SEQ_CAS, SEQ_MODE} seq_e;
  typedef enum logic [1:0] {CMD_INIT, CMD_OP2, CMD_OP3} cmd_e;

  // classify an offset-0 write from data bits 4:3
  function automatic cmd_e classify(input logic [1:0] sel);
    if (sel[1])      return CMD_INIT;
    else if (sel[0]) return CMD_OP3;
    else             return CMD_OP2;
  endfunction
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_master,
  input  logic             init_wr,
  input  logic             cfg_wr,
  input  logic [LINES-1:0] wdata,
  output logic             edge_mode,
  output logic             single_mode,
  output logic [LINES-1:0] vec_base,
  output logic [LINES-1:0] cascade_map,
  output logic             auto_eoi,
  output logic [LINES-1:0] mask
);
  localparam int LINE_W = $clog2(LINES);

  seq_e             state;
  logic             want_mode;
  logic [LINES-1:0] slave_id;

  assign slave_id = LINES'(wdata[LINE_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SEQ_IDLE;
      want_mode   <= 1'b0;
      edge_mode   <= 1'b0;
      single_mode <= 1'b0;
      vec_base    <= '0;
      cascade_map <= '0;
      auto_eoi    <= 1'b0;
      mask        <= '0;
    end else if (init_wr) begin
      edge_mode   <= wdata[3];
      single_mode <= wdata[1];
      want_mode   <= wdata[0];
      if (!wdata[0]) auto_eoi <= 1'b0;
      mask        <= '0;
      state       <= SEQ_VEC;
    end else if (cfg_wr) begin
      unique case (state)
        SEQ_IDLE: mask <= wdata;
        SEQ_VEC: begin
          vec_base <= {wdata[LINES-1:LINE_W], {LINE_W{1'b0}}};
          if (single_mode) begin
            cascade_map <= '0;
            state       <= SEQ_IDLE;
          end else begin
            state <= SEQ_CAS;
          end
        end
        SEQ_CAS: begin
          cascade_map <= is_master ? wdata : slave_id;
          state       <= want_mode ? SEQ_MODE : SEQ_IDLE;
        end
        SEQ_MODE: begin
          auto_eoi <= wdata[1];
          state    <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pic_op_cmd.sv
module pic_op_cmd #(
  parameter int LINES  = 8,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op2_wr,
  input  logic              op3_wr,
  input  logic [2:0]        op_code,
  input  logic [LINE_W-1:0] op_arg,
  input  logic [LINES-1:0]  isr_in,
  output logic              eoi_valid,
  output logic [LINE_W-1:0] eoi_line,
  output logic              sel_irr
);
  localparam logic [2:0] CODE_NS_EOI = 3'b001;
  localparam logic [2:0] CODE_SP_EOI = 3'b011;

  logic [LINE_W-1:0] top_line;

  always_comb begin
    top_line = '0;
    for (int i = 0; i < LINES; i++) begin
      if (isr_in[i]) top_line = LINE_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_valid <= 1'b0;
      eoi_line  <= '0;
      sel_irr   <= 1'b1;
    end else begin
      eoi_valid <= 1'b0;
      if (op2_wr) begin
        if (op_code == CODE_NS_EOI && |isr_in) begin
          eoi_valid <= 1'b1;
          eoi_line  <= top_line;
        end else if (op_code == CODE_SP_EOI) begin
          eoi_valid <= 1'b1;
          eoi_line  <= op_arg;
        end
      end
      if (op3_wr && op_arg[1]) sel_irr <= op_arg[0];
    end
  end
endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             addr,
  input  logic             sel_irr,
  input  logic [LINES-1:0] irr_in,
  input  logic [LINES-1:0] isr_in,
  input  logic [LINES-1:0] mask,
  output logic [LINES-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= addr ? mask : (sel_irr ? irr_in : isr_in);
  end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LINES-1:0]  wdata,
  output logic [LINES-1:0]  rdata,
  input  logic [LINES-1:0]  irr_in,
  input  logic [LINES-1:0]  isr_in,
  output logic              eoi_valid,
  output logic [LINE_W-1:0] eoi_line,
  output logic              edge_mode,
  output logic              single_mode,
  output logic [LINES-1:0]  vec_base,
  output logic [LINES-1:0]  cascade_map,
  output logic              auto_eoi,
  output logic [LINES-1:0]  mask
);
  cmd_e kind;
  logic wr0, init_wr, op2_wr, op3_wr, cfg_wr, sel_irr;

  assign kind    = classify(wdata[4:3]);
  assign wr0     = wr_en && !addr;
  assign init_wr = wr0 && (kind == CMD_INIT);
  assign op2_wr  = wr0 && (kind == CMD_OP2);
  assign op3_wr  = wr0 && (kind == CMD_OP3);
  assign cfg_wr  = wr_en && addr;

  pic_init_seq #(.LINES(LINES)) u_seq (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .init_wr(init_wr), .cfg_wr(cfg_wr), .wdata(wdata),
    .edge_mode(edge_mode), .single_mode(single_mode), .vec_base(vec_base),
    .cascade_map(cascade_map), .auto_eoi(auto_eoi), .mask(mask)
  );

  pic_op_cmd #(.LINES(LINES), .LINE_W(LINE_W)) u_op (
    .clk(clk), .rst_n(rst_n), .op2_wr(op2_wr), .op3_wr(op3_wr),
    .op_code(wdata[7:5]), .op_arg(wdata[LINE_W-1:0]), .isr_in(isr_in),
    .eoi_valid(eoi_valid), .eoi_line(eoi_line), .sel_irr(sel_irr)
  );

  pic_rd_mux #(.LINES(LINES)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .sel_irr(sel_irr),
    .irr_in(irr_in), .isr_in(isr_in), .mask(mask), .rdata(rdata)
  );
endmodule

// File: rtl/irq_cmd_decoder_chk.sv
module irq_cmd_decoder_chk #(
  parameter int LINES  = 8,
  parameter int LINE_W = $clog2(LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [LINES-1:0]  wdata,
  input logic [LINES-1:0]  rdata,
  input logic [LINES-1:0]  mask,
  input logic              auto_eoi,
  input logic              eoi_valid,
  input logic [LINE_W-1:0] eoi_line
);
  a_r2_init_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask == '0));

  a_r6_mask_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask));

  a_r5_auto_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(auto_eoi));

  a_r8_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[7:3] == 5'b01100)
      |=> (eoi_valid && eoi_line == $past(wdata[LINE_W-1:0])));

  a_r7_eoi_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(wr_en && !addr && wdata[4:3] == 2'b00));

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_cmd_decoder irq_cmd_decoder_chk #(.LINES(LINES), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .mask(mask), .auto_eoi(auto_eoi),
  .eoi_valid(eoi_valid), .eoi_line(eoi_line)
);

// File: tb/irq_cmd_decoder_tb.sv
`timescale 1ns/1ps
module irq_cmd_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
  logic [7:0] rdata, vec_base, cascade_map, mask;
  logic [2:0] eoi_line;
  logic eoi_valid, edge_mode, single_mode, auto_eoi;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .irr_in(irr_in), .isr_in(isr_in), .eoi_valid(eoi_valid),
    .eoi_line(eoi_line), .edge_mode(edge_mode), .single_mode(single_mode),
    .vec_base(vec_base), .cascade_map(cascade_map), .auto_eoi(auto_eoi),
    .mask(mask)
  );

  // behavioural reference: step = 0 idle, 1 vector, 2 cascade, 3 mode
  int m_step = 0;
  bit m_four = 0, m_edge = 0, m_single = 0, m_auto = 0, m_irr = 1, m_eoi = 0;
  int m_line = 0;
  logic [7:0] m_vec = 0, m_map = 0, m_mask = 0, m_rd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_step = 0; m_four = 0; m_edge = 0; m_single = 0; m_auto = 0;
      m_irr = 1; m_eoi = 0; m_line = 0; m_vec = 0; m_map = 0; m_mask = 0; m_rd = 0;
    end else begin
      m_eoi = 0;
      if (rd_en) m_rd = addr ? m_mask : (m_irr ? irr_in : isr_in);
      if (wr_en && !addr) begin
        if (wdata[4]) begin
          m_edge = wdata[3]; m_single = wdata[1]; m_four = wdata[0];
          if (!m_four) m_auto = 0;
          m_mask = 0; m_step = 1;
        end else if (wdata[3]) begin
          if (wdata[1]) m_irr = wdata[0];
        end else if (wdata[7:5] == 3'd1) begin
          for (int i = 0; i < 8; i++) if (isr_in[i]) begin m_eoi = 1; m_line = i; end
        end else if (wdata[7:5] == 3'd3) begin
          m_eoi = 1; m_line = wdata[2:0];
        end
      end else if (wr_en && addr) begin
        case (m_step)
          0: m_mask = wdata;
          1: begin
            m_vec = wdata & 8'hF8;
            if (m_single) begin m_map = 0; m_step = 0; end else m_step = 2;
          end
          2: begin
            m_map = is_master ? wdata : (wdata & 8'h07);
            m_step = m_four ? 3 : 0;
          end
          default: begin m_auto = wdata[1]; m_step = 0; end
        endcase
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the reference on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 mask", mask, m_mask);
      chk("R3 vec_base", vec_base, m_vec);
      chk("R4 cascade_map", cascade_map, m_map);
      chk("R5 auto_eoi", auto_eoi, m_auto);
      chk("R2 edge_mode", edge_mode, m_edge);
      chk("R2 single_mode", single_mode, m_single);
      chk("R7 eoi_valid", eoi_valid, m_eoi);
      if (m_eoi) chk("R8 eoi_line", eoi_line, m_line);
      chk("R11 rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic role);
    rst_n = 1'b0; is_master = role;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    irr_in = 8'hA5; isr_in = 8'h3C;
    do_reset(1'b1);
    // R1 reset state
    chk("R1 mask", mask, 0);
    chk("R1 auto_eoi", auto_eoi, 0);
    rd(1'b0);
    chk("R1 read irr", rdata, 8'hA5);
    // R10 readback select
    wr(1'b0, 8'h0A); rd(1'b0);
    chk("R10 select isr", rdata, 8'h3C);
    wr(1'b0, 8'h09); rd(1'b0);
    chk("R10 bit1 clear keeps isr", rdata, 8'h3C);
    wr(1'b0, 8'h0B); rd(1'b0);
    chk("R10 select irr", rdata, 8'hA5);
    // R6 idle mask load, R11 read offset 1
    wr(1'b1, 8'h5A);
    chk("R6 mask load", mask, 8'h5A);
    rd(1'b1);
    chk("R11 read mask", rdata, 8'h5A);
    // long setup, cascade master, mode word
    wr(1'b0, 8'h11);
    chk("R2 mask cleared", mask, 0);
    wr(1'b1, 8'h47);
    chk("R3 vec_base low bits", vec_base, 8'h40);
    wr(1'b1, 8'hC3);
    chk("R4 master map", cascade_map, 8'hC3);
    wr(1'b1, 8'hFE);
    chk("R5 auto_eoi set", auto_eoi, 1);
    wr(1'b1, 8'h77);
    chk("R5 sequence closed, mask", mask, 8'h77);
    // short single setup clears auto_eoi
    wr(1'b0, 8'h1A);
    chk("R2 auto cleared", auto_eoi, 0);
    chk("R2 edge", edge_mode, 1);
    wr(1'b1, 8'h28);
    chk("R3 map cleared", cascade_map, 0);
    wr(1'b1, 8'h0F);
    chk("R3 sequence ended", mask, 8'h0F);
    // end-of-interrupt commands
    wr(1'b0, 8'h20);
    chk("R7 ns strobe", eoi_valid, 1);
    chk("R7 ns line", eoi_line, 5);
    @(negedge clk);
    chk("R7 one cycle", eoi_valid, 0);
    isr_in = 8'h00;
    wr(1'b0, 8'h20);
    chk("R7 empty isr no strobe", eoi_valid, 0);
    isr_in = 8'h81;
    wr(1'b0, 8'h66);
    chk("R8 specific strobe", eoi_valid, 1);
    chk("R8 specific line", eoi_line, 6);
    wr(1'b0, 8'hA0);
    chk("R9 rotate no strobe", eoi_valid, 0);
    wr(1'b0, 8'hC3);
    chk("R9 priority no strobe", eoi_valid, 0);
    chk("R9 mask untouched", mask, 8'h0F);
    wr(1'b0, 8'h00);
    chk("R9 code 000 no strobe", eoi_valid, 0);
    // R12 restart in the middle, then single mode skips mode word
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h80);
    chk("R12 restart vector", vec_base, 8'h80);
    wr(1'b1, 8'h02);
    chk("R3 single skips mode word", mask, 8'h02);
    chk("R5 auto unchanged", auto_eoi, 0);
    // slave role
    do_reset(1'b0);
    chk("R1 slave reset map", cascade_map, 0);
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'hFD);
    chk("R4 slave id", cascade_map, 8'h05);
    wr(1'b1, 8'h00);
    chk("R5 auto clear", auto_eoi, 0);
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'hFF);
    chk("R4 slave id no mode", cascade_map, 8'h07);
    wr(1'b1, 8'h33);
    chk("R4 closed then mask", mask, 8'h33);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule